// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port Controller

This block is a memory-mapped controller for one general-purpose I/O port. A simple register bus (address, write data, write enable, combinational read data) reaches a data register, a direction register, the per-pin interrupt configuration, the interrupt status views and a per-pin hand-over to a peripheral. Accesses below offset 0x400 form a data window. Address bits [9:2] act as a pin mask there, so software can set, clear or sample any subset of pins in one access, with no read-modify-write.

Every pin input passes through a two-stage synchronizer. Each pin can be configured to detect a level or an edge. In edge mode it reacts to one chosen edge or to both edges. Detected edges stay latched until software clears them with a write-one-to-clear access. Level conditions follow the pin live. A per-pin enable forms the masked status, and the OR of the masked status drives a single interrupt line. A pin handed to a peripheral takes its output value and output enable from the peripheral side, and the peripheral receives the synchronized pad level.

Top module: `pio_port`

## Requirements
- R1: After reset every register reads 0, pin_oe is 0 (all pins inputs), pin_out is 0 and irq is 0.
- R2: A write at an address below 0x400 updates only the data bits whose mask bit is 1, with the mask taken from address bits [9:2]. A read there returns the pin view in the masked positions and 0 in all other positions.
- R3: The direction register sits at 0x400, and a bit value of 1 makes that pin an output (pin_oe=1, pin_out from the data register). For a direction bit of 1 the data-window read returns the data register bit. For a direction bit of 0 it returns the synchronized pad level, which is visible two clocks after the pad changes.
- R4: In edge mode (sense register 0x404 bit=0) with both-edges off (0x408 bit=0), the polarity register (0x40C) selects the edge: a bit of 1 latches the raw status bit on a rising edge and a bit of 0 latches it on a falling edge. The opposite edge has no effect.
- R5: In edge mode with the both-edges bit set to 1, a rising edge and a falling edge each latch the raw status bit.
- R6: In level mode (sense bit=1), the raw status bit follows the synchronized level live: it is high while the pin is high when the polarity bit is 1, and while the pin is low when the polarity bit is 0. A clear write leaves it unchanged.
- R7: The masked status (0x418) equals the raw status (0x414) ANDed with the enable register (0x410). irq is the OR of the masked status bits.
- R8: Writing 1 to a bit of the clear register (0x41C) clears that pin's latched edge, and writing 0 leaves the bit set. The clear register reads 0.
- R9: When a new edge is detected on a pin in the same cycle as a clear write to that pin, the raw status bit stays set.
- R10: When an alternate-function bit (0x420) is 1, pin_out and pin_oe for that pin come from periph_out and periph_oe, and periph_in carries the synchronized pad level. When the bit is 0, periph_in is 0 for that pin.
- R11: The configuration registers read back what was written. Writes to the raw and masked status offsets and reads of unmapped offsets at or above 0x400 have no effect and return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 8 | Write data, one bit per pin |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| pin_in | input | 8 | Asynchronous pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| periph_out | input | 8 | Peripheral-side output values |
| periph_oe | input | 8 | Peripheral-side output enables |
| periph_in | output | 8 | Synchronized pad levels for pins handed to the peripheral |
| irq | output | 1 | Port interrupt, OR of the masked status |

## Verification
The bench builds the block with its default values: eight pins, a 12-bit address and an 8-bit data lane. At these values the full mask field [9:2] of the data window is live, as is each of the eight per-pin configuration bits. Different pins are given different sense, edge and polarity settings in the same run, so that one pin cannot disturb the status of its neighbours. With a fixed two-stage synchronizer, the bench can place a clear write exactly on the cycle in which an edge is detected.

// File: rtl/pio_pkg.sv
// Shared constants for the general-purpose I/O port controller.
// Assumes a 12-bit byte address; offsets are fixed by the software view.
package pio_pkg;
    localparam logic [11:0] OFS_DIR   = 12'h400;
    localparam logic [11:0] OFS_SENSE = 12'h404;
    localparam logic [11:0] OFS_BOTH  = 12'h408;
    localparam logic [11:0] OFS_POL   = 12'h40C;
    localparam logic [11:0] OFS_EN    = 12'h410;
    localparam logic [11:0] OFS_RAW   = 12'h414;
    localparam logic [11:0] OFS_MSK   = 12'h418;
    localparam logic [11:0] OFS_CLR   = 12'h41C;
    localparam logic [11:0] OFS_ALT   = 12'h420;

    // Per-pin interrupt configuration, one bit per pin in each field.
    typedef struct packed {
        logic [7:0] sense;  // 1 = level, 0 = edge
        logic [7:0] both;   // 1 = both edges
        logic [7:0] pol;    // 1 = rising/high, 0 = falling/low
    } irq_cfg_t;
endpackage

// File: rtl/pio_sync.sv
// Synchronizes asynchronous pad inputs and keeps one further sample
// for edge detection. Assumes STAGES >= 2; all flops reset to 0.
module pio_sync #(
    parameter int NPINS  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_async,
    output logic [NPINS-1:0] level_cur,
    output logic [NPINS-1:0] level_prev
);
    logic [NPINS-1:0] chain [STAGES];
    logic [NPINS-1:0] prev_q;

    // First synchronizer stage samples the pad.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= pin_async;
    end

    // Remaining synchronizer stages.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
        end
    end

    // Previous synchronized sample for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= chain[STAGES-1];
    end

    assign level_cur  = chain[STAGES-1];
    assign level_prev = prev_q;
endmodule

// File: rtl/pio_irq_detect.sv
// Per-pin interrupt condition detection. Edge conditions latch until a
// clear pulse; level conditions follow the synchronized level live.
// A new edge in the cycle of a clear keeps the bit set.
module pio_irq_detect #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] level_cur,
    input  logic [NPINS-1:0] level_prev,
    input  logic [NPINS-1:0] sense,
    input  logic [NPINS-1:0] both,
    input  logic [NPINS-1:0] pol,
    input  logic [NPINS-1:0] clr_pulse,
    output logic [NPINS-1:0] edge_hit,
    output logic [NPINS-1:0] raw_status
);
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic rise, fall, latch_q;

        // Edge classification for this pin.
        always_comb begin
            rise = level_cur[p] & ~level_prev[p];
            fall = ~level_cur[p] & level_prev[p];
            if (sense[p])     edge_hit[p] = 1'b0;
            else if (both[p]) edge_hit[p] = rise | fall;
            else              edge_hit[p] = pol[p] ? rise : fall;
        end

        // Edge latch: set wins over clear, held empty in level mode.
        always_ff @(posedge clk) begin
            if (!rst_n)           latch_q <= 1'b0;
            else if (sense[p])    latch_q <= 1'b0;
            else if (edge_hit[p]) latch_q <= 1'b1;
            else if (clr_pulse[p]) latch_q <= 1'b0;
        end

        // Raw status: live level in level mode, latch in edge mode.
        always_comb begin
            if (sense[p]) raw_status[p] = pol[p] ? level_cur[p] : ~level_cur[p];
            else          raw_status[p] = latch_q;
        end
    end
endmodule

// File: rtl/pio_regfile.sv
// Register bank and bus decode: masked data window, direction, interrupt
// configuration, enable, alternate-function select and clear pulses.
// Assumes word-aligned configuration accesses; reads are combinational.
module pio_regfile
    import pio_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    input  logic              bus_we,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  level_cur,
    input  logic [NPINS-1:0]  raw_status,
    output logic [NPINS-1:0]  data_q,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  sense_q,
    output logic [NPINS-1:0]  both_q,
    output logic [NPINS-1:0]  pol_q,
    output logic [NPINS-1:0]  en_q,
    output logic [NPINS-1:0]  alt_q,
    output logic [NPINS-1:0]  clr_pulse
);
    localparam int MASK_LSB = 2;
    localparam int MASK_MSB = MASK_LSB + NPINS - 1;

    logic             in_window;
    logic [NPINS-1:0] pin_mask;
    logic [NPINS-1:0] pin_view;

    // Decode of the masked data window.
    always_comb begin
        in_window = (bus_addr[ADDR_W-1:10] == '0);
        pin_mask  = bus_addr[MASK_MSB:MASK_LSB];
        pin_view  = (dir_q & data_q) | (~dir_q & level_cur);
    end

    // Masked data register update.
    always_ff @(posedge clk) begin
        if (!rst_n)                  data_q <= '0;
        else if (bus_we && in_window) data_q <= (data_q & ~pin_mask) | (bus_wdata & pin_mask);
    end

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= '0;
            sense_q <= '0;
            both_q  <= '0;
            pol_q   <= '0;
            en_q    <= '0;
            alt_q   <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                ADDR_W'(OFS_DIR):   dir_q   <= bus_wdata;
                ADDR_W'(OFS_SENSE): sense_q <= bus_wdata;
                ADDR_W'(OFS_BOTH):  both_q  <= bus_wdata;
                ADDR_W'(OFS_POL):   pol_q   <= bus_wdata;
                ADDR_W'(OFS_EN):    en_q    <= bus_wdata;
                ADDR_W'(OFS_ALT):   alt_q   <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Write-one-to-clear pulse toward the detector.
    always_comb begin
        clr_pulse = (bus_we && bus_addr == ADDR_W'(OFS_CLR)) ? bus_wdata : '0;
    end

    // Combinational read multiplexer.
    always_comb begin
        if (in_window) bus_rdata = pin_view & pin_mask;
        else begin
            case (bus_addr)
                ADDR_W'(OFS_DIR):   bus_rdata = dir_q;
                ADDR_W'(OFS_SENSE): bus_rdata = sense_q;
                ADDR_W'(OFS_BOTH):  bus_rdata = both_q;
                ADDR_W'(OFS_POL):   bus_rdata = pol_q;
                ADDR_W'(OFS_EN):    bus_rdata = en_q;
                ADDR_W'(OFS_RAW):   bus_rdata = raw_status;
                ADDR_W'(OFS_MSK):   bus_rdata = raw_status & en_q;
                ADDR_W'(OFS_ALT):   bus_rdata = alt_q;
                default:            bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pio_port.sv
// Top of the general-purpose I/O port controller. Joins synchronizer,
// register bank and detector, muxes pad drive between software and
// peripheral, and forms the single interrupt line.
// Assumes NPINS <= 8 so the pin mask fits address bits [9:2].
module pio_port #(
    parameter int NPINS       = 8,
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    input  logic              bus_we,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    input  logic [NPINS-1:0]  periph_out,
    input  logic [NPINS-1:0]  periph_oe,
    output logic [NPINS-1:0]  periph_in,
    output logic              irq
);
    logic [NPINS-1:0] level_cur, level_prev;
    logic [NPINS-1:0] data_q, dir_q, sense_q, both_q, pol_q, en_q, alt_q;
    logic [NPINS-1:0] clr_pulse, edge_hit, raw_status;

    pio_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_async(pin_in),
        .level_cur(level_cur), .level_prev(level_prev)
    );

    pio_regfile #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .level_cur(level_cur),
        .raw_status(raw_status), .data_q(data_q), .dir_q(dir_q),
        .sense_q(sense_q), .both_q(both_q), .pol_q(pol_q), .en_q(en_q),
        .alt_q(alt_q), .clr_pulse(clr_pulse)
    );

    pio_irq_detect #(.NPINS(NPINS)) u_det (
        .clk(clk), .rst_n(rst_n), .level_cur(level_cur), .level_prev(level_prev),
        .sense(sense_q), .both(both_q), .pol(pol_q), .clr_pulse(clr_pulse),
        .edge_hit(edge_hit), .raw_status(raw_status)
    );

    // Pad drive: peripheral owns pins whose alternate bit is set.
    always_comb begin
        pin_out   = (alt_q & periph_out) | (~alt_q & data_q);
        pin_oe    = (alt_q & periph_oe)  | (~alt_q & dir_q);
        periph_in = alt_q & level_cur;
    end

    // Port interrupt from enabled raw status.
    assign irq = |(raw_status & en_q);
endmodule

// File: rtl/pio_port_chk.sv
// Assertion checker for pio_port, attached through bind.
module pio_port_chk
    import pio_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NPINS-1:0]  bus_wdata,
    input logic              bus_we,
    input logic [NPINS-1:0]  bus_rdata,
    input logic [NPINS-1:0]  data_q,
    input logic [NPINS-1:0]  sense_q,
    input logic [NPINS-1:0]  en_q,
    input logic [NPINS-1:0]  edge_hit,
    input logic [NPINS-1:0]  raw_status,
    input logic              irq
);
    logic              data_wr;
    logic [NPINS-1:0]  wr_mask;
    logic              clr_wr;
    assign data_wr = bus_we && (bus_addr[ADDR_W-1:10] == '0);
    assign wr_mask = bus_addr[NPINS+1:2];
    assign clr_wr  = bus_we && (bus_addr == ADDR_W'(OFS_CLR));

    // R2: data bits outside the address mask do not move on a window write
    a_r2_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> ((data_q ^ $past(data_q)) & ~$past(wr_mask)) == '0);

    // R7: masked status read and irq agree with raw status and enables
    a_r7_masked_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_MSK)) |->
            (bus_rdata == (raw_status & en_q)) && (irq == (|bus_rdata)));

    // R8: a clear write with no new edge empties latched edge bits
    a_r8_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && ((bus_wdata & ~edge_hit & ~sense_q) != '0) && !data_wr) |=>
            ((raw_status & $past(bus_wdata & ~edge_hit & ~sense_q) & ~sense_q) == '0));

    // R4: with no bus write, latched edge bits stay set
    a_r4_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> (($past(raw_status & ~sense_q) & ~sense_q & ~raw_status) == '0));

    // R9: an edge coinciding with a clear leaves the raw bit set
    a_r9_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && ((edge_hit & bus_wdata) != '0)) |=>
            ((raw_status & $past(edge_hit & bus_wdata)) == $past(edge_hit & bus_wdata)));
endmodule

bind pio_port pio_port_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .data_q(data_q), .sense_q(sense_q),
    .en_q(en_q), .edge_hit(edge_hit), .raw_status(raw_status), .irq(irq)
);

// File: tb/pio_port_bench.sv
// Directed bench for pio_port: one task per scenario, each self-checking.
module pio_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out, pin_oe, periph_in;
    logic [7:0]  periph_out = '0, periph_oe = '0;
    logic        irq;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    pio_port u_pio_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .periph_out(periph_out), .periph_oe(periph_oe),
        .periph_in(periph_in), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 12'h7FC;
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic clear_all();
        wr(12'h404, 8'h00); wr(12'h408, 8'h00); wr(12'h40C, 8'h00);
        wr(12'h410, 8'h00); wr(12'h41C, 8'hFF);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int a = 'h400; a <= 'h420; a += 4) begin
            rd(12'(a), v); check("R1 reg reset", v, 8'h00);
        end
        check("R1 pin_oe", pin_oe, 8'h00);
        check("R1 pin_out", pin_out, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_data_mask();
        logic [7:0] v;
        wr(12'h400, 8'hFF);
        check("R3 oe follows dir", pin_oe, 8'hFF);
        wr(12'h3FC, 8'hA5);
        check("R2 full mask write", pin_out, 8'hA5);
        wr(12'h03C, 8'hFF);
        check("R2 partial mask write", pin_out, 8'hAF);
        rd(12'h3C0, v); check("R2 masked read", v, 8'hA0);
        rd(12'h000, v); check("R2 zero mask read", v, 8'h00);
    endtask

    task automatic t_input_read();
        logic [7:0] v;
        wr(12'h400, 8'h0F);
        @(negedge clk); pin_in = 8'h30;
        @(negedge clk);
        rd(12'h3FC, v); check("R3 input read after two clocks", v, 8'h3F);
        pin_in = 8'h00;
        wr(12'h400, 8'h00);
        settle(); clear_all();
    endtask

    task automatic t_edge_single();
        logic [7:0] v;
        clear_all();
        wr(12'h40C, 8'h01);
        @(negedge clk); pin_in = 8'h03; settle();
        rd(12'h414, v); check("R4 rising only on pin0", v, 8'h01);
        check("R7 irq masked", {7'b0, irq}, 8'h00);
        wr(12'h41C, 8'h00);
        rd(12'h414, v); check("R8 zero clear no effect", v, 8'h01);
        @(negedge clk); pin_in = 8'h00; settle();
        rd(12'h414, v); check("R4 falling on pin1", v, 8'h03);
        wr(12'h41C, 8'h02);
        rd(12'h414, v); check("R8 clear pin1 only", v, 8'h01);
        rd(12'h41C, v); check("R8 clear reads zero", v, 8'h00);
        wr(12'h41C, 8'hFF);
        rd(12'h414, v); check("R8 clear all", v, 8'h00);
    endtask

    task automatic t_both();
        logic [7:0] v;
        clear_all();
        wr(12'h408, 8'h04);
        @(negedge clk); pin_in = 8'h04; settle();
        rd(12'h414, v); check("R5 rise on both-edge pin2", v, 8'h04);
        wr(12'h41C, 8'h04);
        @(negedge clk); pin_in = 8'h00; settle();
        rd(12'h414, v); check("R5 fall on both-edge pin2", v, 8'h04);
        wr(12'h410, 8'h04);
        rd(12'h418, v); check("R7 masked status", v, 8'h04);
        check("R7 irq asserted", {7'b0, irq}, 8'h01);
        wr(12'h410, 8'h00);
        check("R7 irq after disable", {7'b0, irq}, 8'h00);
        wr(12'h41C, 8'hFF);
    endtask

    task automatic t_level();
        logic [7:0] v;
        clear_all();
        wr(12'h404, 8'h08); wr(12'h40C, 8'h08);
        rd(12'h414, v); check("R6 high level idle", v, 8'h00);
        @(negedge clk); pin_in = 8'h08; @(negedge clk);
        rd(12'h414, v); check("R6 high level live", v, 8'h08);
        wr(12'h41C, 8'h08);
        rd(12'h414, v); check("R6 clear no effect", v, 8'h08);
        wr(12'h40C, 8'h00);
        rd(12'h414, v); check("R6 low polarity pin high", v, 8'h00);
        @(negedge clk); pin_in = 8'h00; settle();
        rd(12'h414, v); check("R6 low level live", v, 8'h08);
        clear_all();
    endtask

    task automatic t_coincide();
        logic [7:0] v;
        clear_all();
        wr(12'h408, 8'h10);
        @(negedge clk); pin_in = 8'h10; settle();
        rd(12'h414, v); check("R9 setup latched", v, 8'h10);
        // new edge detected in the cycle the clear lands
        pin_in = 8'h00;
        @(negedge clk); @(negedge clk);
        bus_addr = 12'h41C; bus_wdata = 8'h10; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
        settle();
        rd(12'h414, v); check("R9 edge wins over clear", v, 8'h10);
        wr(12'h41C, 8'h10);
        rd(12'h414, v); check("R9 later clear", v, 8'h00);
        clear_all();
    endtask

    task automatic t_alt();
        wr(12'h400, 8'hFF); wr(12'h3FC, 8'h0F);
        wr(12'h420, 8'hC0);
        @(negedge clk); periph_out = 8'h80; periph_oe = 8'h40; pin_in = 8'hC3;
        settle();
        check("R10 pin_out mux", pin_out, 8'h8F);
        check("R10 pin_oe mux", pin_oe, 8'h7F);
        check("R10 periph_in gated", periph_in, 8'hC0);
        pin_in = 8'h00; settle();
        wr(12'h420, 8'h00); wr(12'h400, 8'h00); clear_all();
    endtask

    task automatic t_regmap();
        logic [7:0] v;
        wr(12'h410, 8'h5A); rd(12'h410, v); check("R11 enable readback", v, 8'h5A);
        wr(12'h40C, 8'h3C); rd(12'h40C, v); check("R11 polarity readback", v, 8'h3C);
        wr(12'h420, 8'h81); rd(12'h420, v); check("R11 alt readback", v, 8'h81);
        wr(12'h420, 8'h00); wr(12'h410, 8'h00); wr(12'h40C, 8'h00);
        wr(12'h414, 8'hFF); rd(12'h414, v); check("R11 raw read-only", v, 8'h00);
        wr(12'h418, 8'hFF); rd(12'h418, v); check("R11 masked read-only", v, 8'h00);
        wr(12'h424, 8'hFF); rd(12'h424, v); check("R11 unmapped reads zero", v, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_data_mask();
        t_input_read();
        t_edge_single();
        t_both();
        t_level();
        t_coincide();
        t_alt();
        t_regmap();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule